// File: doc/BRIEF.md
# Multi-lane 8b/10b encoder with per-lane disparity override

This block turns a parallel word of one, two or four bytes into 10-bit 8b/10b code groups, one group per byte lane, on every cycle of a single parallel clock. Each lane has three controls of its own. The first picks a control (K) or data (D) code group. The second switches the lane from automatic running disparity to a forced starting disparity. The third chooses which disparity is forced.

Running disparity flows through the lanes in ascending order within a cycle. The ending disparity of the last lane seeds lane 0 on the next cycle. A forced lane breaks the chain at its start only, and the lanes after it continue from its ending disparity. The force controls are treated as asynchronous and pass through a two-flop synchronizer. The data and K/D select are used as sampled. The code groups and a per-lane error flag for illegal control bytes leave the block through registers.

Top module: `lane_encoder_8b10b`

## Requirements
- R1: Parameter `LANES` (1, 2 or 4) sets the width: byte lane l is `data_i[8l+7:8l]` and drives `code_o[10l+9:10l]`, so lane 0 is in the least significant bits. The per-lane controls use bit l of `ctrl_i`, `force_i` and `force_val_i`.
- R2: With `ctrl_i[l]`=1 and a legal control byte (K28.0 to K28.7, K23.7, K27.7, K29.7, K30.7), the lane emits the matching K code group. For example, K28.5 (byte 8'hBC) from negative disparity gives 10'h0FA and from positive disparity gives 10'h305.
- R3: With `ctrl_i[l]`=0, the byte is emitted as the Dx.y data code group, where x is bits [4:0] and y is bits [7:5].
- R4: Within each 10-bit group, bits [9:4] hold the 6b sub-block abcdei (a in bit 9) and bits [3:0] hold fghj (f in bit 3). An unforced lane encodes from the running disparity left by the lane below it. Lane 0 starts from the disparity left by the top lane on the previous cycle.
- R5: With `force_i[l]`=1 and `force_val_i[l]`=1, the lane encodes starting from negative disparity.
- R6: With `force_i[l]`=1 and `force_val_i[l]`=0, the lane encodes starting from positive disparity.
- R7: `force_i` and `force_val_i` take effect two cycles late. The code word registered at clock edge n uses the force values sampled at edge n-2. The inputs must be held for at least two cycles.
- R8: While `rst_ni` is low, `code_o` and `kerr_o` are zero and the running disparity is negative.
- R9: D.x.7 uses the alternate fghj code 0111/1000 when x is 17, 18 or 20 at negative disparity, or when x is 11, 13 or 14 at positive disparity. This avoids runs of five equal bits.
- R10: With `ctrl_i[l]`=1 on a byte that is not a legal control byte, `kerr_o[l]` is 1 in the same cycle as that lane's code group, and the lane is encoded as data.
- R11: `code_o` and `kerr_o` appear one clock after the data and K/D select are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 8*LANES | Byte lanes to encode |
| ctrl_i | input | LANES | Per-lane K/D select, 1 = control |
| force_i | input | LANES | Per-lane forced-disparity enable (asynchronous) |
| force_val_i | input | LANES | Per-lane forced value, 1 = negative start (asynchronous) |
| code_o | output | 10*LANES | Registered code groups |
| kerr_o | output | LANES | Registered illegal-control-byte flags |

## Verification
The bench drives K28.5 on every lane just after reset and checks the literal 0FA/305 alternation. This catches a design whose disparity chain does not pass from lane to lane, or that starts from positive disparity. Sweeps of D.x.7 across all x, together with the complemented balanced fghj codes of K28.y, expose a wrong alternate-code rule or K28 column. Either fault shows up as a mismatched group and a disparity that drifts from then on.

Force patterns are held for three cycles and compared against a model that applies them exactly two edges late. A design with one stage too few or too many in the synchronizer, or with the forced polarity swapped, mismatches on the edge cycles. Illegal control bytes check that the error flag lines up with its code group and that the lane still carries data.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;

  typedef struct packed {
    logic [9:0] code;
    logic       rd;
    logic       kerr;
  } enc_res_t;

  function automatic logic [5:0] tbl6(input logic [4:0] x);
    case (x)
      5'd0:  tbl6 = 6'b100111;  5'd1:  tbl6 = 6'b011101;
      5'd2:  tbl6 = 6'b101101;  5'd3:  tbl6 = 6'b110001;
      5'd4:  tbl6 = 6'b110101;  5'd5:  tbl6 = 6'b101001;
      5'd6:  tbl6 = 6'b011001;  5'd7:  tbl6 = 6'b111000;
      5'd8:  tbl6 = 6'b111001;  5'd9:  tbl6 = 6'b100101;
      5'd10: tbl6 = 6'b010101;  5'd11: tbl6 = 6'b110100;
      5'd12: tbl6 = 6'b001101;  5'd13: tbl6 = 6'b101100;
      5'd14: tbl6 = 6'b011100;  5'd15: tbl6 = 6'b010111;
      5'd16: tbl6 = 6'b011011;  5'd17: tbl6 = 6'b100011;
      5'd18: tbl6 = 6'b010011;  5'd19: tbl6 = 6'b110010;
      5'd20: tbl6 = 6'b001011;  5'd21: tbl6 = 6'b101010;
      5'd22: tbl6 = 6'b011010;  5'd23: tbl6 = 6'b111010;
      5'd24: tbl6 = 6'b110011;  5'd25: tbl6 = 6'b100110;
      5'd26: tbl6 = 6'b010110;  5'd27: tbl6 = 6'b110110;
      5'd28: tbl6 = 6'b001110;  5'd29: tbl6 = 6'b101110;
      5'd30: tbl6 = 6'b011110;  default: tbl6 = 6'b101011;
    endcase
  endfunction

  // negative-disparity column
  function automatic logic [3:0] tbl4(input logic [2:0] y);
    case (y)
      3'd0: tbl4 = 4'b1011;  3'd1: tbl4 = 4'b1001;
      3'd2: tbl4 = 4'b0101;  3'd3: tbl4 = 4'b1100;
      3'd4: tbl4 = 4'b1101;  3'd5: tbl4 = 4'b1010;
      3'd6: tbl4 = 4'b0110;  default: tbl4 = 4'b1110;
    endcase
  endfunction

  // rd: 1 = positive running disparity
  function automatic enc_res_t enc_byte(input logic [7:0] b, input logic k, input logic rd);
    enc_res_t   r;
    logic [4:0] x;
    logic [2:0] y;
    logic       kok, k28, rdm, alt;
    logic [5:0] c6, o6;
    logic [3:0] c4, o4;
    x   = b[4:0];
    y   = b[7:5];
    kok = k && (x == 5'd28 ||
               (y == 3'd7 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30)));
    k28 = kok && (x == 5'd28);
    c6  = k28 ? 6'b001111 : tbl6(x);
    if ($countones(c6) == 3) o6 = (x == 5'd7 && rd) ? ~c6 : c6;
    else                     o6 = rd ? ~c6 : c6;
    rdm = ($countones(o6) == 3) ? rd : ~rd;
    alt = (y == 3'd7) && (kok ||
          (!rdm && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
          ( rdm && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    c4  = alt ? 4'b0111 : tbl4(y);
    if ($countones(c4) == 2) begin
      o4 = (y == 3'd3 && rdm) ? ~c4 : c4;
      if (k28 && y != 3'd3 && !rdm) o4 = ~c4;
    end else begin
      o4 = rdm ? ~c4 : c4;
    end
    r.code = {o6, o4};
    r.rd   = ($countones(o4) == 2) ? rdm : ~rdm;
    r.kerr = k && !kok;
    return r;
  endfunction

endpackage

// File: rtl/enc_force_sync.sv
module enc_force_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/enc_lane.sv
module enc_lane
  import enc8b10b_pkg::*;
(
  input  logic [7:0] byte_i,
  input  logic       k_i,
  input  logic       rd_i,
  output logic [9:0] code_o,
  output logic       rd_o,
  output logic       kerr_o
);
  enc_res_t res;

  always_comb res = enc_byte(byte_i, k_i, rd_i);

  assign code_o = res.code;
  assign rd_o   = res.rd;
  assign kerr_o = res.kerr;
endmodule

// File: rtl/lane_encoder_8b10b.sv
module lane_encoder_8b10b #(
  parameter int LANES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [8*LANES-1:0]  data_i,
  input  logic [LANES-1:0]    ctrl_i,
  input  logic [LANES-1:0]    force_i,
  input  logic [LANES-1:0]    force_val_i,
  output logic [10*LANES-1:0] code_o,
  output logic [LANES-1:0]    kerr_o
);
  localparam int DW = 8 * LANES;
  localparam int CW = 10 * LANES;

  logic [LANES-1:0]   frc_s, val_s;
  logic [LANES:0]     rd_chain;
  logic [LANES-1:0]   rd_start, lane_kerr;
  logic [CW-1:0]      lane_code;
  logic               rd_q;
  logic [CW-1:0]      code_q;
  logic [LANES-1:0]   kerr_q;

  enc_force_sync #(.W(2 * LANES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({force_val_i, force_i}),
    .q_o    ({val_s, frc_s})
  );

  assign rd_chain[0] = rd_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // forced value 1 selects negative start (rd = 0)
    assign rd_start[l] = frc_s[l] ? ~val_s[l] : rd_chain[l];

    enc_lane u_lane (
      .byte_i (data_i[8*l +: 8]),
      .k_i    (ctrl_i[l]),
      .rd_i   (rd_start[l]),
      .code_o (lane_code[10*l +: 10]),
      .rd_o   (rd_chain[l+1]),
      .kerr_o (lane_kerr[l])
    );

    a_r4_start_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_start[l] |-> $countones(lane_code[10*l +: 10]) >= 5);
    a_r4_start_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_start[l] |-> $countones(lane_code[10*l +: 10]) <= 5);
    a_r4_sub6_bal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(lane_code[10*l+4 +: 6]) inside {2, 3, 4});
    a_r10_kerr_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kerr_q[l] |-> $past(ctrl_i[l]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      code_q <= '0;
      kerr_q <= '0;
    end else begin
      rd_q   <= rd_chain[LANES];
      code_q <= lane_code;
      kerr_q <= lane_kerr;
    end
  end

  assign code_o = code_q;
  assign kerr_o = kerr_q;

  logic unused_dw;
  assign unused_dw = (DW == 0);
endmodule

// File: tb/tb_lane_encoder_8b10b.sv
`timescale 1ns/1ps
module tb_lane_encoder_8b10b;
  localparam int LANES = 4;

  logic                clk_i = 1'b0;
  logic                rst_ni;
  logic [8*LANES-1:0]  data_i;
  logic [LANES-1:0]    ctrl_i, force_i, force_val_i;
  logic [10*LANES-1:0] code_o;
  logic [LANES-1:0]    kerr_o;

  lane_encoder_8b10b #(.LANES(LANES)) dut (.*);

  always #5 clk_i = ~clk_i;

  int    total = 0;
  int    bad   = 0;
  string tag   = "R8";

  // model state
  logic                rd_m;
  logic [LANES-1:0]    fh1, fh2, vh1, vh2;
  logic [10*LANES-1:0] exp_code;
  logic [LANES-1:0]    exp_kerr;

  function automatic logic [5:0] t6(input int x);
    logic [5:0] v [32];
    v = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001, 6'b011001, 6'b111000,
          6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100, 6'b011100, 6'b010111,
          6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
          6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
    return v[x];
  endfunction

  // returns {kerr, code}
  function automatic logic [10:0] ref_enc(input logic [7:0] b, input logic k, input logic rd);
    int x, y, n;
    logic valid, is28, rdm, alt;
    logic [5:0] s6;
    logic [3:0] s4;
    logic [3:0] n4 [8];
    logic [3:0] p4 [8];
    n4 = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    p4 = '{4'b0100, 4'b1001, 4'b0101, 4'b0011, 4'b0010, 4'b1010, 4'b0110, 4'b0001};
    x = int'(b[4:0]);
    y = int'(b[7:5]);
    valid = k && (x == 28 || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)));
    is28  = valid && x == 28;
    s6 = is28 ? 6'b001111 : t6(x);
    n = $countones(s6);
    if (n == 3) begin
      if (x == 7 && !is28) s6 = rd ? 6'b000111 : 6'b111000;
    end else if (rd) s6 = ~s6;
    n = $countones(s6);
    rdm = (n > 3) ? 1'b1 : (n < 3) ? 1'b0 : rd;
    alt = (y == 7) && (valid || (!rdm && (x == 17 || x == 18 || x == 20)) ||
                                 (rdm && (x == 11 || x == 13 || x == 14)));
    if (alt) s4 = rdm ? 4'b1000 : 4'b0111;
    else     s4 = rdm ? p4[y] : n4[y];
    if (is28 && !rdm && (y == 1 || y == 2 || y == 5 || y == 6)) s4 = ~s4;
    return {k && !valid, s6, s4};
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [10:0] r;
    logic rd;
    int n;
    rd = rd_m;
    for (int l = 0; l < LANES; l++) begin
      if (fh2[l]) rd = ~vh2[l];        // R5 / R6: value 1 = negative start
      r = ref_enc(data_i[8*l +: 8], ctrl_i[l], rd);
      exp_code[10*l +: 10] = r[9:0];
      exp_kerr[l] = r[10];
      n = $countones(r[9:0]);
      if (n > 5) rd = 1'b1;
      else if (n < 5) rd = 1'b0;
    end
    rd_m = rd;
    fh2 = fh1; vh2 = vh1;              // R7: two-stage delay
    fh1 = force_i; vh1 = force_val_i;
  endtask

  // at a negedge: drive, model the posedge, compare at next negedge (R11)
  task automatic step(input logic [8*LANES-1:0] d, input logic [LANES-1:0] k,
                      input logic [LANES-1:0] f, input logic [LANES-1:0] v);
    data_i = d; ctrl_i = k; force_i = f; force_val_i = v;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check(64'(code_o), 64'(exp_code), "code_o");
    check(64'(kerr_o), 64'(exp_kerr), "kerr_o");
  endtask

  function automatic logic [7:0] rand_k();
    int s;
    s = $urandom_range(0, 11);
    if (s < 8) return {3'(s), 5'd28};
    case (s)
      8: return 8'hF7;  9: return 8'hFB;  10: return 8'hFD;  default: return 8'hFE;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [8*LANES-1:0] d;
    logic [LANES-1:0] k, f, v;
    rd_m = 1'b0; fh1 = '0; fh2 = '0; vh1 = '0; vh2 = '0;
    data_i = '0; ctrl_i = '0; force_i = '0; force_val_i = '0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    tag = "R8";
    check(64'(code_o), 64'd0, "reset code_o");
    check(64'(kerr_o), 64'd0, "reset kerr_o");
    rst_ni = 1'b1;

    // R2 R1 R8: K28.5 alternates 0FA/305 from negative start
    tag = "R2";
    step({LANES{8'hBC}}, '1, '0, '0);
    for (int l = 0; l < LANES; l++)
      check(64'(code_o[10*l +: 10]), (l % 2 == 0) ? 64'h0FA : 64'h305, "K28.5 literal");
    // R3: D21.5 balanced, same in either disparity
    tag = "R3";
    step({LANES{8'hB5}}, '0, '0, '0);
    for (int l = 0; l < LANES; l++)
      check(64'(code_o[10*l +: 10]), 64'h2AA, "D21.5 literal");

    // R3 R4: random data stream
    tag = "R4";
    for (int i = 0; i < 300; i++) step(DW'($urandom), '0, '0, '0);

    // R2: every legal K code in every lane
    tag = "R2";
    for (int i = 0; i < 200; i++) begin
      for (int l = 0; l < LANES; l++) d[8*l +: 8] = rand_k();
      step(d, '1, '0, '0);
    end

    // R9: D.x.7 sweep
    tag = "R9";
    for (int x = 0; x < 32; x++)
      for (int j = 0; j < 4; j++) begin
        for (int l = 0; l < LANES; l++)
          d[8*l +: 8] = {3'd7, 5'((x + l * j) % 32)};
        step(d, '0, '0, '0);
      end

    // R5 R6 R7: forced disparity, held three cycles
    tag = "R7";
    for (int i = 0; i < 150; i++) begin
      f = LANES'($urandom); v = LANES'($urandom);
      for (int h = 0; h < 3; h++) begin
        for (int l = 0; l < LANES; l++) begin
          d[8*l +: 8] = 8'($urandom);
          k[l] = $urandom_range(0, 3) == 0;
          if (k[l]) d[8*l +: 8] = rand_k();
        end
        step(d, k, f, v);
      end
    end
    tag = "R5";
    for (int h = 0; h < 6; h++) step({LANES{8'h00}}, '0, '1, '1);
    tag = "R6";
    for (int h = 0; h < 6; h++) step({LANES{8'h00}}, '0, '1, '0);
    for (int h = 0; h < 3; h++) step({LANES{8'h00}}, '0, '0, '0);

    // R10: illegal control bytes
    tag = "R10";
    for (int i = 0; i < 150; i++) begin
      d = DW'($urandom);
      k = LANES'($urandom);
      step(d, k, '0, '0);
    end
    step({LANES{8'h00}}, '1, '0, '0);
    check(64'(kerr_o), 64'({LANES{1'b1}}), "K0.0 flagged");

    // R1 R11: everything mixed
    tag = "R1";
    for (int i = 0; i < 600; i++) begin
      d = DW'($urandom);
      k = LANES'($urandom);
      if ((i % 7) == 0) begin
        f = LANES'($urandom); v = LANES'($urandom);
      end
      step(d, k, f, v);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam int DW = 8 * LANES;
endmodule